// File: doc/BRIEF.md
# Sparse Pulse-Height Readout Sequencer

This block drains the results of one detector event from a daisy chain of pulse-height front-end chips. The chips share a 24-bit parallel bus. Only channels that fired put a word on it, so the number of words in an event varies. The sequencer strobes the bus once per word and waits for the chain to signal that the word is valid. It then splits the word into its fields, repacks them into a 22-bit record and writes that record into an external output FIFO for the host processor. The word that carries the end-of-chain token is the last one. The sequencer stops after storing it and raises a one-cycle done pulse. The number of records written stays readable until the next start.

The front end chooses the gain before a word reaches the bus. A channel reports its high-gain amplitude unless that value is at full scale, and then reports its low-gain amplitude. The flag that says which chain was used travels with the word and passes straight into the record. Two guards keep a broken chain from hanging the host:
- a word limit, reached without a token;
- a per-word bus timeout.

Either guard ends the readout with a sticky error flag. When the FIFO is full, the sequencer holds back its read strobe rather than dropping a word.

The controller has five states. IDLE waits for a start. FETCH asserts the read strobe and waits for the bus. STORE writes the captured record. FINISH pulses done after a token word. FAULT pulses done with the error flag set. The transitions are:
- IDLE to FETCH on start;
- FETCH to STORE on a bus handshake;
- FETCH to FAULT on timeout;
- STORE to FINISH after the write of a token word;
- STORE to FAULT after the write of the last word the limit allows;
- STORE to FETCH after any other write;
- FINISH and FAULT to IDLE unconditionally.

Top module: `ph_readout_seq`

## Requirements
- R1: After reset the block is idle. bus_rd_o, fifo_wr_o, done_o and err_o are 0, and word_cnt_o is 0.
- R2: start_i is acted on only in IDLE. From the next cycle the block requests words, and the count and the error flag are cleared. A start_i pulse during a readout has no effect on its outputs.
- R3: A bus word is taken in a cycle where bus_rd_o and bus_rdy_i are both 1. Its record is written to the FIFO exactly once, with a single-cycle fifo_wr_o, starting in the next cycle.
- R4: The bus word holds the amplitude in bits 10:0, overflow in bit 11 and the low-gain flag in bit 14. It holds the channel in 18:15, the chip in 22:19 and the token in bit 23. The record holds the amplitude in 10:0, overflow in 11 and the low-gain flag in 12. It holds the channel in 16:13, the chip in 20:17 and the token in 21. Input bits 12 and 13 are dropped.
- R5: After the write of a record whose token bit is set, done_o is 1 for exactly one cycle, in the cycle that follows the write. No further bus strobe follows for that event.
- R6: word_cnt_o counts the records written in the current event and holds that value until the next accepted start.
- R7: While fifo_full_i is 1, bus_rd_o and fifo_wr_o stay 0. No word is lost, and the record is written once space returns.
- R8: If MAX_WORDS records have been written without a token, err_o is set, done_o pulses on the next cycle and the block returns to IDLE with word_cnt_o = MAX_WORDS.
- R9: If bus_rd_o has been 1 for TIMEOUT consecutive cycles without bus_rdy_i, err_o is set and done_o pulses on the next cycle. The count keeps the records already written.
- R10: err_o stays 1 from the abort until the next accepted start.
- R11: bus_rdy_i in a cycle where bus_rd_o is 0 takes no word and causes no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request for one event readout |
| bus_rdy_i | input | 1 | Bus word valid |
| bus_data_i | input | 24 | Bus word from the chip chain |
| bus_rd_o | output | 1 | Bus read strobe |
| fifo_full_i | input | 1 | Output FIFO full |
| fifo_wr_o | output | 1 | FIFO write enable |
| fifo_data_o | output | 22 | Repacked record |
| done_o | output | 1 | One-cycle end-of-readout pulse |
| err_o | output | 1 | Readout aborted by word limit or timeout |
| word_cnt_o | output | CNT_W (9) | Records written in the current event |

## Verification
The hardest case to reach from the ports is a full FIFO and a ready bus arriving together. The bench must show both that the strobe is withheld and that a ready bus outside the strobe takes no word. To get there, the bench's responder keeps the ready line high whenever it has a word queued, and a periodic full pattern is overlaid on it. The two limits are reached by feeding an event of exactly the word limit with no token, and by queuing a single word and then going silent. Every cycle is compared against a behavioural model.

// File: rtl/ph_seq_pkg.sv
package ph_seq_pkg;

    localparam int BUS_W = 24;
    localparam int AMP_W = 11;
    localparam int ADR_W = 4;

    typedef struct packed {
        logic             last;
        logic [ADR_W-1:0] chip;
        logic [ADR_W-1:0] chan;
        logic             low_gain;
        logic             ovf;
        logic [AMP_W-1:0] amp;
    } ph_rec_t;

    localparam int REC_W = $bits(ph_rec_t);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_STORE,
        ST_FINISH,
        ST_FAULT
    } seq_state_e;

endpackage

// File: rtl/ph_word_unpack.sv
module ph_word_unpack
    import ph_seq_pkg::*;
(
    input  logic [BUS_W-1:0] word_i,
    output ph_rec_t          rec_o
);

    // Bit positions are fixed by the front-end chips that drive the bus.
    always_comb begin
        rec_o.amp      = word_i[AMP_W-1:0];
        rec_o.ovf      = word_i[11];
        rec_o.low_gain = word_i[14];
        rec_o.chan     = word_i[18:15];
        rec_o.chip     = word_i[22:19];
        rec_o.last     = word_i[23];
    end

endmodule

// File: rtl/ph_word_counter.sv
module ph_word_counter #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (clr_i) begin
            cnt_o <= '0;
        end else if (inc_i) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

endmodule

// File: rtl/ph_wait_timer.sv
module ph_wait_timer #(
    parameter int LIMIT = 64,
    localparam int W = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic tick_i,
    output logic expired_o
);

    logic [W-1:0] waited_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            waited_q <= '0;
        end else if (clr_i) begin
            waited_q <= '0;
        end else if (tick_i) begin
            waited_q <= waited_q + 1'b1;
        end
    end

    assign expired_o = tick_i && (waited_q == W'(LIMIT - 1));

endmodule

// File: rtl/ph_readout_seq.sv
module ph_readout_seq
    import ph_seq_pkg::*;
#(
    parameter int MAX_WORDS = 256,
    parameter int TIMEOUT   = 64,
    parameter int CNT_W     = $clog2(MAX_WORDS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             bus_rdy_i,
    input  logic [BUS_W-1:0] bus_data_i,
    output logic             bus_rd_o,
    input  logic             fifo_full_i,
    output logic             fifo_wr_o,
    output logic [REC_W-1:0] fifo_data_o,
    output logic             done_o,
    output logic             err_o,
    output logic [CNT_W-1:0] word_cnt_o
);

    seq_state_e state_q, state_d;
    ph_rec_t    rec_d, rec_q;
    logic       take, go, timed_out, at_limit;

    ph_word_unpack u_unpack (
        .word_i (bus_data_i),
        .rec_o  (rec_d)
    );

    ph_word_counter #(.W(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (go),
        .inc_i (fifo_wr_o),
        .cnt_o (word_cnt_o)
    );

    ph_wait_timer #(.LIMIT(TIMEOUT)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (state_q != ST_FETCH),
        .tick_i    (bus_rd_o && !bus_rdy_i),
        .expired_o (timed_out)
    );

    assign go       = (state_q == ST_IDLE) && start_i;
    assign take     = bus_rd_o && bus_rdy_i;
    assign at_limit = (word_cnt_o == CNT_W'(MAX_WORDS - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_FETCH;
            end
            ST_FETCH: begin
                if (take)           state_d = ST_STORE;
                else if (timed_out) state_d = ST_FAULT;
            end
            ST_STORE: begin
                if (fifo_wr_o) begin
                    if (rec_q.last)    state_d = ST_FINISH;
                    else if (at_limit) state_d = ST_FAULT;
                    else               state_d = ST_FETCH;
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            ST_FAULT:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        bus_rd_o  = 1'b0;
        fifo_wr_o = 1'b0;
        done_o    = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_FETCH:  bus_rd_o  = !fifo_full_i;
            ST_STORE:  fifo_wr_o = !fifo_full_i;
            ST_FINISH: done_o    = 1'b1;
            ST_FAULT:  done_o    = 1'b1;
            default:   ;
        endcase
    end

    assign fifo_data_o = rec_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rec_q <= '0;
        end else if (take) begin
            rec_q <= rec_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_o <= 1'b0;
        end else if (go) begin
            err_o <= 1'b0;
        end else if (state_d == ST_FAULT && state_q != ST_FAULT) begin
            err_o <= 1'b1;
        end
    end

endmodule

// File: rtl/ph_readout_chk.sv
module ph_readout_chk #(
    parameter int MAX_WORDS = 256,
    parameter int CNT_W     = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             bus_rdy_i,
    input logic             bus_rd_o,
    input logic             fifo_full_i,
    input logic             fifo_wr_o,
    input logic             done_o,
    input logic             err_o,
    input logic [CNT_W-1:0] word_cnt_o
);

    // R3
    handshake_then_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_o && bus_rdy_i) |=> !bus_rd_o);

    // R3
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_o |=> !fifo_wr_o);

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !bus_rd_o && !fifo_wr_o);

    // R6
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_wr_o && !start_i) |=> $stable(word_cnt_o));

    // R7
    full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full_i |-> !(bus_rd_o || fifo_wr_o));

    // R8
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_cnt_o <= CNT_W'(MAX_WORDS));

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !start_i) |=> err_o);

endmodule

bind ph_readout_seq ph_readout_chk #(.MAX_WORDS(MAX_WORDS), .CNT_W(CNT_W)) chk_i (.*);

// File: tb/ph_readout_seq_tb_top.sv
`timescale 1ns/1ps
module ph_readout_seq_tb_top;

    localparam int MAXW = 256;
    localparam int TOUT = 64;
    localparam int CW   = $clog2(MAXW + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          bus_rdy_i = 1'b0;
    logic [23:0]   bus_data_i = '0;
    logic          bus_rd_o, fifo_full_i = 1'b0, fifo_wr_o, done_o, err_o;
    logic [21:0]   fifo_data_o;
    logic [CW-1:0] word_cnt_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int rdy_mode = 0;
    int full_mode = 0;
    logic [23:0] bq[$];
    logic [21:0] expq[$];
    int pops = 0;
    int writes = 0;

    // model state
    int m_ph = 0;
    logic [21:0] m_held = '0;
    int m_cnt = 0;
    int m_wait = 0;
    bit m_err = 0;

    always #2 clk = ~clk;

    ph_readout_seq #(.MAX_WORDS(MAXW), .TIMEOUT(TOUT)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .bus_rdy_i(bus_rdy_i),
        .bus_data_i(bus_data_i), .bus_rd_o(bus_rd_o), .fifo_full_i(fifo_full_i),
        .fifo_wr_o(fifo_wr_o), .fifo_data_o(fifo_data_o), .done_o(done_o),
        .err_o(err_o), .word_cnt_o(word_cnt_o)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [21:0] rec_of(input logic [23:0] w);
        return {w[23], w[22:19], w[18:15], w[14], w[11], w[10:0]};
    endfunction

    // bus responder and FIFO-full pattern
    always @(posedge clk) begin
        #1;
        cyc++;
        bus_rdy_i   <= (bq.size() > 0) && (rdy_mode == 0 || (cyc % 3) != 1);
        bus_data_i  <= (bq.size() > 0) ? bq[0] : 24'hA5A5A5;
        fifo_full_i <= (full_mode != 0) && ((cyc % 5) == 2 || (cyc % 5) == 3);
    end

    // cycle-by-cycle reference model, compared at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            bit e_rd, e_wr;
            e_rd = (m_ph == 1) && !fifo_full_i;
            e_wr = (m_ph == 2) && !fifo_full_i;
            chk(bus_rd_o == e_rd, "R7 bus_rd_o", bus_rd_o, e_rd);
            chk(fifo_wr_o == e_wr, "R3 fifo_wr_o", fifo_wr_o, e_wr);
            if (e_wr) chk(fifo_data_o == m_held, "R4 fifo_data_o", fifo_data_o, m_held);
            chk(done_o == (m_ph >= 3), "R5 done_o", done_o, m_ph >= 3);
            chk(err_o == m_err, "R10 err_o", err_o, m_err);
            chk(word_cnt_o == CW'(m_cnt), "R6 word_cnt_o", word_cnt_o, m_cnt);
            if (fifo_wr_o) writes++;
            case (m_ph)
                0: if (start_i) begin m_ph = 1; m_cnt = 0; m_err = 0; m_wait = 0; end
                1: if (e_rd && bus_rdy_i) begin
                       m_held = rec_of(bus_data_i); m_ph = 2; m_wait = 0;
                       void'(bq.pop_front()); pops++;
                   end else if (e_rd) begin
                       if (m_wait == TOUT - 1) begin m_ph = 4; m_err = 1; end
                       else m_wait++;
                   end
                2: if (e_wr) begin
                       m_cnt++;
                       if (m_held[21]) m_ph = 3;
                       else if (m_cnt == MAXW) begin m_ph = 4; m_err = 1; end
                       else m_ph = 1;
                   end
                default: m_ph = 0;
            endcase
        end
    end

    task automatic kick();
        @(posedge clk); #1 start_i = 1'b1;
        @(posedge clk); #1 start_i = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (done_o !== 1'b1 && n < 5000) begin @(negedge clk); n++; end
        @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(!bus_rd_o && !fifo_wr_o && !done_o && !err_o, "R1 reset outputs",
            {bus_rd_o, fifo_wr_o, done_o, err_o}, 0);
        chk(word_cnt_o == 0, "R1 reset count", word_cnt_o, 0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // event A: three words, clean bus
        bq.push_back({1'b0, 4'd2, 4'd5, 1'b0, 2'b11, 1'b0, 11'h123});
        bq.push_back({1'b0, 4'd7, 4'd15, 1'b1, 2'b00, 1'b1, 11'h7FF});
        bq.push_back({1'b1, 4'd15, 4'd0, 1'b0, 2'b10, 1'b0, 11'h001});
        kick();
        wait_done();
        chk(word_cnt_o == 3, "R6 count after token", word_cnt_o, 3);
        chk(!err_o, "R5 clean finish", err_o, 0);
        chk(!bus_rd_o, "R5 no strobe after token", bus_rd_o, 0);

        // event B: gaps, full pattern, start while busy
        rdy_mode = 1; full_mode = 1;
        for (int i = 0; i < 20; i++)
            bq.push_back({(i == 19), 4'(i), 4'(15 - i), i[0], 2'(i), i[1], 11'(i * 97)});
        kick();
        repeat (10) @(posedge clk);
        kick();
        wait_done();
        chk(word_cnt_o == 20, "R2 busy start ignored", word_cnt_o, 20);
        chk(pops == 23 && writes == 23, "R11 one write per handshake", writes, pops);
        rdy_mode = 0; full_mode = 0;

        // event C: word limit without token
        for (int i = 0; i < MAXW; i++) bq.push_back(24'h000100 + 24'(i));
        kick();
        wait_done();
        chk(err_o, "R8 limit error", err_o, 1);
        chk(word_cnt_o == CW'(MAXW), "R8 limit count", word_cnt_o, MAXW);
        repeat (4) @(posedge clk);
        #1 chk(err_o, "R10 error held", err_o, 1);

        // event D: single token word clears error
        bq.push_back(24'h800ABC);
        kick();
        wait_done();
        chk(!err_o, "R10 cleared by start", err_o, 0);
        chk(word_cnt_o == 1, "R6 single word", word_cnt_o, 1);

        // event E: one word then a silent bus
        bq.push_back(24'h012345);
        kick();
        wait_done();
        chk(err_o, "R9 timeout error", err_o, 1);
        chk(word_cnt_o == 1, "R9 count kept", word_cnt_o, 1);

        repeat (5) @(posedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule